// File: doc/BRIEF.md
# External Write Request Bus Slave

This block sits on the processor side of a shared address/data system interface. It accepts single-word writes that an outside agent starts. While the processor owns the interface (master mode), the block watches an active-low request line. When the agent pulls that line low, the block grants the interface with a one-clock active-low release pulse. It then turns its own bus drivers off and behaves as a slave.

In slave mode the agent makes two valid cycles, each marked by an active-low input-valid strobe. The first carries a write command and the target address. The second carries a data identifier and the write word. The block checks both codes. After one turnaround cycle it reclaims the interface. It reports either a one-clock write-done pulse, with the latched address, data, coherency flag and check bits, or a one-clock protocol-error pulse.

Command encoding, with the command bus `CMD_W` bits wide (default 5): the top bit is 0 for a command and 1 for a data identifier. A write of one word is the command whose lower `CMD_W-1` bits equal `WR1_CODE` (default 4'b1000, so the full word is 5'b01000). In a data identifier, bit 0 marks the last data cycle, bit 1 marks a non-coherent write, and bits `CMD_W-2` down to 2 are reserved and must be zero.

Top module: `ext_wr_slave`

## Requirements
- R1: While reset is low and after it, `release_n` is 1, `bus_oe` is 1, `wr_done` and `proto_err` are 0, and the latched address, data and check outputs are 0.
- R2: If `ext_req_n` is sampled low in master mode, `release_n` is low for exactly the following clock. A request held low outside master mode produces no release.
- R3: `bus_oe` is 1 only in master mode. It is 0 from the release cycle through the single turnaround cycle after the final slave cycle, and it is 1 again in the next cycle.
- R4: Edges where `in_valid_n` is high leave the slave sequence where it is, whatever the buses carry. Valid cycles sampled in the release cycle or the turnaround cycle after it are ignored.
- R5: The first valid slave cycle is accepted only if `cmd_i` is 5'b01000 (top bit 0, lower bits equal to `WR1_CODE`). On acceptance `bus_i` is latched as the address, and it stays unchanged through completion.
- R6: A following valid cycle whose identifier has bit 4 = 1, bit 0 = 1 and bits 3..2 = 0 raises `wr_done` for exactly one clock, in the cycle after that data cycle. In that same cycle the latched address and data are presented.
- R7: `wr_noncoh` presented with `wr_done` equals bit 1 of the data identifier (1 = non-coherent).
- R8: A data cycle whose identifier is not a valid last-cycle identifier raises `proto_err` for one clock in the next cycle, with no `wr_done`, and master mode returns one cycle later.
- R9: A first valid slave cycle that carries any code other than the one-word write raises `proto_err` in the next cycle. No data cycle is awaited, and master mode returns one cycle later.
- R10: `bus_chk_i` and `cmd_chk_i` are latched on the same edges as their buses: with the address and command on the command cycle, and with the data and identifier on the data cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_req_n | input | 1 | Active-low request from the external agent |
| in_valid_n | input | 1 | Active-low strobe marking a valid slave cycle |
| cmd_i | input | CMD_W | Command bus as driven by the agent |
| cmd_chk_i | input | CCHK_W | Check bits of the command bus |
| bus_i | input | BUS_W | Address/data bus as driven by the agent |
| bus_chk_i | input | CHK_W | Check bits of the address/data bus |
| release_n | output | 1 | Active-low one-clock bus grant |
| bus_oe | output | 1 | Processor bus drive enable (1 = processor drives) |
| wr_done | output | 1 | One-clock completion pulse |
| proto_err | output | 1 | One-clock protocol error pulse |
| wr_addr | output | BUS_W | Latched write address |
| wr_data | output | BUS_W | Latched write data |
| wr_noncoh | output | 1 | Latched non-coherent flag |
| wr_addr_chk | output | CHK_W | Check bits latched with the address |
| wr_data_chk | output | CHK_W | Check bits latched with the data |
| wr_cmd_chk | output | CCHK_W | Command check bits latched with the command |
| wr_did_chk | output | CCHK_W | Command check bits latched with the data identifier |

## Verification
A completion and a fresh request can fall in the same cycle. If the agent keeps `ext_req_n` low through the data cycle, the request is present during the turnaround cycle, when `wr_done` is high. The bench provokes this by holding the request across a whole transfer. It then expects `wr_done` with `release_n` still high and `bus_oe` low. It expects one master cycle with `bus_oe` high and no release, and `release_n` low only in the cycle after that. The next transfer then runs from that release and is scored like any other.

// File: rtl/ewr_pkg.sv
package ewr_pkg;

   typedef enum logic [2:0] {
      ST_MASTER   = 3'd0,
      ST_RELEASE  = 3'd1,
      ST_TURN_IN  = 3'd2,
      ST_SLV_CMD  = 3'd3,
      ST_SLV_DATA = 3'd4,
      ST_TURN_OUT = 3'd5
   } ewr_state_e;

   localparam int unsigned DID_LAST_BIT   = 0;
   localparam int unsigned DID_NONCOH_BIT = 1;
   localparam int unsigned DID_RSV_LO     = 2;

endpackage

// File: rtl/ewr_decode.sv
module ewr_decode
   import ewr_pkg::*;
#(
   parameter int unsigned CMD_W    = 5,
   parameter logic [CMD_W-2:0] WR1_CODE = 4'b1000
) (
   input  logic [CMD_W-1:0] cmd_i,
   output logic             cmd_accept,
   output logic             did_final,
   output logic             did_noncoh
);

   localparam int unsigned TOP = CMD_W - 1;
   localparam int unsigned RSV_W = CMD_W - 1 - DID_RSV_LO;

   initial begin : p_param_chk
      assert (CMD_W >= 5) else $error("ewr_decode: CMD_W must be at least 5");
   end

   logic is_id;
   logic rsv_clear;

   assign is_id      = cmd_i[TOP];
   assign rsv_clear  = (cmd_i[CMD_W-2:DID_RSV_LO] == {RSV_W{1'b0}});

   // One-word write command: top bit clear and the lower field matches exactly.
   assign cmd_accept = !is_id && (cmd_i[CMD_W-2:0] == WR1_CODE);

   // Valid final-cycle identifier: top bit set, last mark set, reserved clear.
   assign did_final  = is_id && cmd_i[DID_LAST_BIT] && rsv_clear;
   assign did_noncoh = cmd_i[DID_NONCOH_BIT];

endmodule

// File: rtl/ewr_fsm.sv
module ewr_fsm
   import ewr_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic ext_req_n,
   input  logic in_valid_n,
   input  logic cmd_accept,
   input  logic did_final,
   output logic release_n,
   output logic bus_oe,
   output logic cap_cmd,
   output logic cap_data,
   output logic wr_done,
   output logic proto_err
);

   ewr_state_e state_q, state_d;
   logic       valid;
   logic       err_d;
   logic       done_q, err_q;

   assign valid = !in_valid_n;

   always_comb begin
      state_d  = state_q;
      err_d    = 1'b0;
      cap_cmd  = 1'b0;
      cap_data = 1'b0;
      unique case (state_q)
         ST_MASTER: begin
            if (!ext_req_n) state_d = ST_RELEASE;
         end
         ST_RELEASE: state_d = ST_TURN_IN;
         ST_TURN_IN: state_d = ST_SLV_CMD;
         ST_SLV_CMD: begin
            if (valid) begin
               if (cmd_accept) begin
                  cap_cmd = 1'b1;
                  state_d = ST_SLV_DATA;
               end else begin
                  err_d   = 1'b1;
                  state_d = ST_TURN_OUT;
               end
            end
         end
         ST_SLV_DATA: begin
            if (valid) begin
               state_d = ST_TURN_OUT;
               if (did_final) cap_data = 1'b1;
               else           err_d    = 1'b1;
            end
         end
         ST_TURN_OUT: state_d = ST_MASTER;
         default:     state_d = ST_MASTER;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_MASTER;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         done_q  <= cap_data;
         err_q   <= err_d;
      end
   end

   assign release_n = (state_q != ST_RELEASE);
   assign bus_oe    = (state_q == ST_MASTER);
   assign wr_done   = done_q;
   assign proto_err = err_q;

   AST_REL_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
      !release_n |=> release_n);                                   // R2
   AST_REL_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(release_n) |-> ($past(ext_req_n) == 1'b0));            // R2
   AST_OE_OFF_REL: assert property (@(posedge clk) disable iff (!rst_n)
      !release_n |-> !bus_oe);                                     // R3
   AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == ST_SLV_CMD || state_q == ST_SLV_DATA) && in_valid_n)
      |=> $stable(state_q));                                       // R4
   AST_DONE_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
      wr_done |=> !wr_done);                                       // R6
   AST_ERR_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
      proto_err |=> !proto_err);                                   // R8
   AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_done && proto_err));                                    // R8

endmodule

// File: rtl/ewr_capture.sv
module ewr_capture #(
   parameter int unsigned BUS_W   = 32,
   parameter int unsigned CHK_W   = 4,
   parameter int unsigned CCHK_W  = 1,
   parameter bit          RESET_PAYLOAD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_cmd,
   input  logic              cap_data,
   input  logic [BUS_W-1:0]  bus_i,
   input  logic [CHK_W-1:0]  bus_chk_i,
   input  logic [CCHK_W-1:0] cmd_chk_i,
   input  logic              did_noncoh,
   output logic [BUS_W-1:0]  wr_addr,
   output logic [BUS_W-1:0]  wr_data,
   output logic              wr_noncoh,
   output logic [CHK_W-1:0]  wr_addr_chk,
   output logic [CHK_W-1:0]  wr_data_chk,
   output logic [CCHK_W-1:0] wr_cmd_chk,
   output logic [CCHK_W-1:0] wr_did_chk
);

   generate
      if (RESET_PAYLOAD) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               wr_addr     <= '0;
               wr_addr_chk <= '0;
               wr_cmd_chk  <= '0;
               wr_data     <= '0;
               wr_data_chk <= '0;
               wr_did_chk  <= '0;
               wr_noncoh   <= 1'b0;
            end else begin
               if (cap_cmd) begin
                  wr_addr     <= bus_i;
                  wr_addr_chk <= bus_chk_i;
                  wr_cmd_chk  <= cmd_chk_i;
               end
               if (cap_data) begin
                  wr_data     <= bus_i;
                  wr_data_chk <= bus_chk_i;
                  wr_did_chk  <= cmd_chk_i;
                  wr_noncoh   <= did_noncoh;
               end
            end
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            if (cap_cmd) begin
               wr_addr     <= bus_i;
               wr_addr_chk <= bus_chk_i;
               wr_cmd_chk  <= cmd_chk_i;
            end
            if (cap_data) begin
               wr_data     <= bus_i;
               wr_data_chk <= bus_chk_i;
               wr_did_chk  <= cmd_chk_i;
               wr_noncoh   <= did_noncoh;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/ext_wr_slave.sv
module ext_wr_slave
   import ewr_pkg::*;
#(
   parameter int unsigned BUS_W   = 32,
   parameter int unsigned CHK_W   = 4,
   parameter int unsigned CMD_W   = 5,
   parameter int unsigned CCHK_W  = 1,
   parameter logic [CMD_W-2:0] WR1_CODE = 4'b1000,
   parameter bit          RESET_PAYLOAD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ext_req_n,
   input  logic              in_valid_n,
   input  logic [CMD_W-1:0]  cmd_i,
   input  logic [CCHK_W-1:0] cmd_chk_i,
   input  logic [BUS_W-1:0]  bus_i,
   input  logic [CHK_W-1:0]  bus_chk_i,
   output logic              release_n,
   output logic              bus_oe,
   output logic              wr_done,
   output logic              proto_err,
   output logic [BUS_W-1:0]  wr_addr,
   output logic [BUS_W-1:0]  wr_data,
   output logic              wr_noncoh,
   output logic [CHK_W-1:0]  wr_addr_chk,
   output logic [CHK_W-1:0]  wr_data_chk,
   output logic [CCHK_W-1:0] wr_cmd_chk,
   output logic [CCHK_W-1:0] wr_did_chk
);

   initial begin : p_param_chk
      assert (BUS_W >= 8)  else $error("ext_wr_slave: BUS_W too small");
      assert (CHK_W >= 1)  else $error("ext_wr_slave: CHK_W must be nonzero");
      assert (CCHK_W >= 1) else $error("ext_wr_slave: CCHK_W must be nonzero");
      assert (CMD_W >= 5)  else $error("ext_wr_slave: CMD_W must be at least 5");
   end

   logic cmd_accept, did_final, did_noncoh;
   logic cap_cmd, cap_data;

   ewr_decode #(
      .CMD_W    (CMD_W),
      .WR1_CODE (WR1_CODE)
   ) u_dec (
      .cmd_i      (cmd_i),
      .cmd_accept (cmd_accept),
      .did_final  (did_final),
      .did_noncoh (did_noncoh)
   );

   ewr_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .ext_req_n  (ext_req_n),
      .in_valid_n (in_valid_n),
      .cmd_accept (cmd_accept),
      .did_final  (did_final),
      .release_n  (release_n),
      .bus_oe     (bus_oe),
      .cap_cmd    (cap_cmd),
      .cap_data   (cap_data),
      .wr_done    (wr_done),
      .proto_err  (proto_err)
   );

   ewr_capture #(
      .BUS_W         (BUS_W),
      .CHK_W         (CHK_W),
      .CCHK_W        (CCHK_W),
      .RESET_PAYLOAD (RESET_PAYLOAD)
   ) u_cap (
      .clk         (clk),
      .rst_n       (rst_n),
      .cap_cmd     (cap_cmd),
      .cap_data    (cap_data),
      .bus_i       (bus_i),
      .bus_chk_i   (bus_chk_i),
      .cmd_chk_i   (cmd_chk_i),
      .did_noncoh  (did_noncoh),
      .wr_addr     (wr_addr),
      .wr_data     (wr_data),
      .wr_noncoh   (wr_noncoh),
      .wr_addr_chk (wr_addr_chk),
      .wr_data_chk (wr_data_chk),
      .wr_cmd_chk  (wr_cmd_chk),
      .wr_did_chk  (wr_did_chk)
   );

   AST_DONE_OE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      wr_done |-> !bus_oe);                                        // R3
   AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      wr_done |-> $stable(wr_addr));                               // R5

endmodule

// File: tb/sim_ext_wr_slave.sv
`timescale 1ns/1ps
module sim_ext_wr_slave;

   typedef struct {
      bit          err;
      logic [31:0] addr;
      logic [31:0] data;
      logic        noncoh;
      logic [3:0]  achk;
      logic [3:0]  dchk;
      logic        cchk;
      logic        dcchk;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ext_req_n = 1'b1;
   logic        in_valid_n = 1'b1;
   logic [4:0]  cmd_i = '0;
   logic [0:0]  cmd_chk_i = '0;
   logic [31:0] bus_i = '0;
   logic [3:0]  bus_chk_i = '0;
   logic        release_n, bus_oe, wr_done, proto_err, wr_noncoh;
   logic [31:0] wr_addr, wr_data;
   logic [3:0]  wr_addr_chk, wr_data_chk;
   logic [0:0]  wr_cmd_chk, wr_did_chk;

   int   n_chk = 0;
   int   n_fail = 0;
   bit   ended = 1'b0;
   exp_t exp_q[$];

   always #4 clk = ~clk;

   ext_wr_slave u0 (
      .clk(clk), .rst_n(rst_n), .ext_req_n(ext_req_n), .in_valid_n(in_valid_n),
      .cmd_i(cmd_i), .cmd_chk_i(cmd_chk_i), .bus_i(bus_i), .bus_chk_i(bus_chk_i),
      .release_n(release_n), .bus_oe(bus_oe), .wr_done(wr_done), .proto_err(proto_err),
      .wr_addr(wr_addr), .wr_data(wr_data), .wr_noncoh(wr_noncoh),
      .wr_addr_chk(wr_addr_chk), .wr_data_chk(wr_data_chk),
      .wr_cmd_chk(wr_cmd_chk), .wr_did_chk(wr_did_chk)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   // Monitor: every completion or error pulse pops one expected item.
   always @(negedge clk) begin
      if (rst_n && (wr_done || proto_err)) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R4", "unexpected pulse", {wr_done, proto_err}, 0);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            if (e.err) begin
               chk(proto_err && !wr_done, "R8/R9", "error pulse", {wr_done, proto_err}, 2'b01);
            end else begin
               chk(wr_done && !proto_err, "R6", "done pulse", {wr_done, proto_err}, 2'b10);
               chk(wr_addr == e.addr, "R5", "address", wr_addr, e.addr);
               chk(wr_data == e.data, "R6", "data", wr_data, e.data);
               chk(wr_noncoh == e.noncoh, "R7", "noncoh", wr_noncoh, e.noncoh);
               chk({wr_addr_chk, wr_data_chk, wr_cmd_chk, wr_did_chk} ==
                   {e.achk, e.dchk, e.cchk, e.dcchk}, "R10", "check bits",
                   {wr_addr_chk, wr_data_chk, wr_cmd_chk, wr_did_chk},
                   {e.achk, e.dchk, e.cchk, e.dcchk});
            end
         end
      end
   end

   // Driver: one external write request; expectations pushed from the requirements.
   task automatic run_txn(input logic [31:0] a, input logic [31:0] d,
                          input logic [3:0] ac, input logic [3:0] dc,
                          input logic acc, input logic dcc,
                          input logic [4:0] cw, input logic [4:0] did,
                          input int wc, input int wd, input bit junk, input bit hold);
      exp_t e;
      bit   cmd_ok, did_ok;
      cmd_ok = (cw == 5'b01000);
      did_ok = did[4] && did[0] && (did[3:2] == 2'b00);
      e.err = !(cmd_ok && did_ok);
      e.addr = a; e.data = d; e.noncoh = did[1];
      e.achk = ac; e.dchk = dc; e.cchk = acc; e.dcchk = dcc;
      exp_q.push_back(e);

      ext_req_n = 1'b0;
      @(negedge clk);
      chk(release_n == 1'b0, "R2", "release asserted", release_n, 0);
      chk(bus_oe == 1'b0, "R3", "oe off at release", bus_oe, 0);
      if (!hold) ext_req_n = 1'b1;
      @(negedge clk);
      chk(release_n == 1'b1, "R2", "release one clock", release_n, 1);
      if (junk) begin
         in_valid_n = 1'b0; cmd_i = 5'b10001; bus_i = 32'hBAD0_0001;
      end
      @(negedge clk);
      in_valid_n = 1'b1;
      for (int i = 0; i < wc; i++) begin
         cmd_i = 5'b10011; bus_i = 32'h5A5A_0000 + i;
         @(negedge clk);
         chk(release_n == 1'b1, "R2", "no release in slave", release_n, 1);
      end
      in_valid_n = 1'b0; cmd_i = cw; bus_i = a; bus_chk_i = ac; cmd_chk_i = acc;
      @(negedge clk);
      in_valid_n = 1'b1;
      if (!cmd_ok) begin
         chk(bus_oe == 1'b0, "R9", "oe off in turnaround", bus_oe, 0);
         @(negedge clk);
         chk(bus_oe == 1'b1, "R9", "master after error", bus_oe, 1);
         return;
      end
      for (int i = 0; i < wd; i++) begin
         cmd_i = 5'b10001; bus_i = 32'hC3C3_0000 + i;
         @(negedge clk);
         chk(bus_oe == 1'b0, "R4", "oe off while waiting", bus_oe, 0);
      end
      in_valid_n = 1'b0; cmd_i = did; bus_i = d; bus_chk_i = dc; cmd_chk_i = dcc;
      @(negedge clk);
      in_valid_n = 1'b1; cmd_i = 5'b01000; bus_i = 32'hFFFF_FFFF;
      chk(bus_oe == 1'b0, "R3", "oe off after data", bus_oe, 0);
      chk(release_n == 1'b1, "R2", "no release in turnaround", release_n, 1);
      @(negedge clk);
      chk(bus_oe == 1'b1, "R3", "oe back in master", bus_oe, 1);
      chk(release_n == 1'b1, "R2", "no release on master entry", release_n, 1);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      chk(1'b0, "R1", "watchdog expired", 0, 1);
      finish_run();
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      chk(release_n == 1'b1 && bus_oe == 1'b1, "R1", "reset bus", {release_n, bus_oe}, 2'b11);
      chk(!wr_done && !proto_err, "R1", "reset pulses", {wr_done, proto_err}, 0);
      chk(wr_addr == 0 && wr_data == 0, "R1", "reset payload", {wr_addr, wr_data}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(release_n == 1'b1 && bus_oe == 1'b1, "R1", "idle after reset", {release_n, bus_oe}, 2'b11);

      // Plain coherent write, no waits
      run_txn(32'h1000_0040, 32'hCAFE_F00D, 4'h3, 4'hC, 1'b1, 1'b0, 5'b01000, 5'b10001, 0, 0, 0, 0);
      // Non-coherent with waits and junk in the turnaround cycle (R4, R7)
      run_txn(32'h2000_0080, 32'h0123_4567, 4'h5, 4'hA, 1'b0, 1'b1, 5'b01000, 5'b10011, 3, 2, 1, 0);
      // Data cycle without last mark (R8)
      run_txn(32'h3000_0000, 32'h1111_1111, 4'h1, 4'h2, 1'b0, 1'b0, 5'b01000, 5'b10000, 0, 1, 0, 0);
      // Reserved identifier bits set (R8)
      run_txn(32'h3000_0004, 32'h2222_2222, 4'h1, 4'h2, 1'b0, 1'b0, 5'b01000, 5'b10101, 0, 0, 0, 0);
      // Command code in the data slot (R8)
      run_txn(32'h3000_0008, 32'h3333_3333, 4'h1, 4'h2, 1'b0, 1'b0, 5'b01000, 5'b01000, 0, 0, 0, 0);
      // Multi-word size code, read code, identifier in command slot (R9)
      run_txn(32'h4000_0000, 32'h0, 4'h0, 4'h0, 1'b0, 1'b0, 5'b01001, 5'b10001, 1, 0, 0, 0);
      run_txn(32'h4000_0010, 32'h0, 4'h0, 4'h0, 1'b0, 1'b0, 5'b00000, 5'b10001, 0, 0, 0, 0);
      run_txn(32'h4000_0020, 32'h0, 4'h0, 4'h0, 1'b0, 1'b0, 5'b10001, 5'b10001, 0, 0, 0, 0);
      // Request held across completion, then back-to-back write (R2, R3)
      run_txn(32'h5000_0000, 32'hAAAA_5555, 4'hF, 4'h0, 1'b1, 1'b1, 5'b01000, 5'b10001, 1, 0, 0, 1);
      run_txn(32'h5000_0004, 32'h5555_AAAA, 4'h0, 4'hF, 1'b0, 1'b0, 5'b01000, 5'b10011, 0, 3, 0, 0);

      repeat (4) @(negedge clk);
      chk(exp_q.size() == 0, "R6", "all expected results seen", exp_q.size(), 0);
      chk(release_n == 1'b1 && bus_oe == 1'b1, "R3", "idle at end", {release_n, bus_oe}, 2'b11);
      finish_run();
   end

endmodule